// File: doc/BRIEF.md
# SPI Serial SRAM Slave Interface

This block is the serial front end of an 8K x 8 volatile memory. While chip select is low it shifts in an op-code, a 16-bit address field and write data from the serial input. It shifts read data or the status byte out on the serial output. It drives a synchronous single-port SRAM through an address, write data, write strobe and read data. The SPI pins are resynchronised into the core clock domain. SCK edges are detected there, so the block has one clock and one reset.

Only the low 13 bits of the address field are used. After each data byte, the address counter advances in one of two ways. It can wrap inside a 32-byte page or run across the whole array. A status bit selects which. Writes are accepted only after a write-enable command. Writes to the region chosen by the two-bit protection field of the status register are dropped, but the address still advances past them. A single bit driver outside the block turns `so_o` into the pad, using `so_oe_o` as its enable.

Top module: `sram_spi_slave`

## Requirements
- R1: After reset, so_oe_o and mem_we_o are low and the status byte reads 0x00.
- R2: SPI modes 0 (SCK idle low) and 3 (SCK idle high) both work unchanged, provided each SCK phase lasts at least 6 clk_i cycles.
- R3: SI is taken on the SCK rising edge, most significant bit first. SO changes only after an SCK falling edge and holds steady through the following high phase.
- R4: The first byte after chip select falls is the op-code: 0x03 read, 0x02 write, 0x05 read status, 0x01 write status, 0x06 set write latch, 0x04 clear write latch. Any other code is ignored for the rest of the select and leaves so_oe_o low.
- R5: Memory writes and status writes take effect only while the write latch is set. Op-code 0x06 sets it and 0x04 clears it. Status bit 1 shows the latch.
- R6: Status layout: bit 5 selects rollover (1 = page), bits 3:2 select protection, bit 1 is the write latch, and all other bits read 0. A status write updates bits 5 and 3:2 only.
- R7: Protection codes: 0 none, 1 addresses 0x1800-0x1FFF, 2 addresses 0x1000-0x1FFF, 3 all. A byte aimed at a protected address raises no mem_we_o, and the address still advances.
- R8: With bit 5 clear, the address counter runs through the array and wraps from 0x1FFF to 0x0000.
- R9: With bit 5 set, the low 5 address bits wrap within the page and the upper 8 bits stay fixed, for both read and write.
- R10: Read streams bytes from consecutive addresses for as long as it is clocked. The top 3 bits of the 16-bit address field are ignored.
- R11: Chip select rising at any point aborts the command: a partial byte is discarded, so_oe_o goes low, and the next select starts with an op-code.
- R12: Read status returns the status byte again for every further byte clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the SO pad driver |
| mem_addr_o | output | 13 | SRAM address |
| mem_wdata_o | output | 8 | SRAM write data |
| mem_we_o | output | 1 | SRAM write strobe, one cycle per byte |
| mem_rdata_i | input | 8 | SRAM read data, valid one cycle after the address |

## Verification
The bench aims at the edges of each address space. Page writes starting at 0x3E must land on 0x3E, 0x3F, 0x20 and 0x21. A counter that carried into bit 5 would instead write 0x40 and 0x41. Sequential writes at 0x1FFF must wrap to 0x0000, and a missing wrap would show as a wrong read-back. The protection boundaries 0x17FF/0x1800 and 0x0FFF/0x1000 are straddled by a single burst, so an off-by-one decode or a counter that stalls on a blocked byte corrupts the neighbouring byte. Writes without the latch and aborts in the middle of a byte or a command are checked through the write strobe count and the read-back, where a design that keeps stale bits would write or misframe the next op-code.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_READ, ST_WRITE, ST_RDSR, ST_WRSR, ST_IDLE
  } state_e;

  typedef enum logic [1:0] {
    PROT_NONE, PROT_QUARTER, PROT_HALF, PROT_ALL
  } prot_e;
endpackage

// File: rtl/sram_spi_sync.sv
module sram_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sel_o,
  output logic si_o
);
  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] si_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[STAGES-1:0], sck_i};
      cs_q  <= {cs_q[STAGES-2:0], cs_ni};
      si_q  <= {si_q[STAGES-2:0], si_i};
    end
  end

  // extra sck stage gives the edge; data and select align with sck_q[STAGES-1]
  assign sck_rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign sel_o      = ~cs_q[STAGES-1];
  assign si_o       = si_q[STAGES-1];
endmodule

// File: rtl/sram_spi_prot.sv
module sram_spi_prot
  import sram_spi_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0] addr_i,
  input  prot_e         mode_i,
  output logic          locked_o
);
  always_comb begin
    unique case (mode_i)
      PROT_NONE:    locked_o = 1'b0;
      PROT_QUARTER: locked_o = &addr_i[AW-1:AW-2];
      PROT_HALF:    locked_o = addr_i[AW-1];
      default:      locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sram_spi_addr.sv
module sram_spi_addr #(
  parameter int AW     = 13,
  parameter int PAGE_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  input  logic          page_mode_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_inc;

  always_comb begin
    if (page_mode_i)
      addr_inc = {addr_q[AW-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
    else
      addr_inc = addr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (adv_i)  addr_q <= addr_inc;
  end

  assign addr_o = addr_o_sel();
  function automatic logic [AW-1:0] addr_o_sel();
    return addr_q;
  endfunction

  p_page_upper_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && page_mode_i) |=> (addr_q[AW-1:PAGE_W] == $past(addr_q[AW-1:PAGE_W])))
    else $error("page advance changed upper address bits");

  p_page_low_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && page_mode_i && (&addr_q[PAGE_W-1:0])) |=> (addr_q[PAGE_W-1:0] == '0))
    else $error("page advance did not wrap low bits");

  p_array_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !page_mode_i && (&addr_q)) |=> (addr_q == '0))
    else $error("array advance did not wrap to zero");
endmodule

// File: rtl/sram_spi_slave.sv
module sram_spi_slave
  import sram_spi_pkg::*;
#(
  parameter int AW          = 13,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          si_i,
  output logic          so_o,
  output logic          so_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam int BIT_W = 3;

  logic sck_rise, sck_fall, sel, si_s;

  sram_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sel_o(sel), .si_o(si_s)
  );

  state_e            state_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [6:0]        rx_sh_q;
  logic [7:0]        rx_byte;
  logic [7:0]        addr_hi_q;
  logic              addr_ph_q, is_rd_q;
  logic              wel_q, page_q;
  prot_e             bp_q;
  logic [7:0]        tx_q;
  logic              tx_vld_q;
  logic              we_q, adv_q;
  logic [7:0]        wdata_q;
  logic [7:0]        status;
  logic              byte_done, load_addr, locked;
  logic [AW-1:0]     addr;

  assign rx_byte   = {rx_sh_q, si_s};
  assign byte_done = sel && sck_rise && (&bit_cnt_q);
  assign load_addr = byte_done && (state_q == ST_ADDR) && addr_ph_q;
  assign status    = {2'b00, page_q, 1'b0, bp_q, wel_q, 1'b0};

  sram_spi_addr #(.AW(AW), .PAGE_W(PAGE_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(load_addr), .load_addr_i(AW'({addr_hi_q, rx_byte})),
    .adv_i(adv_q), .page_mode_i(page_q), .addr_o(addr)
  );

  sram_spi_prot #(.AW(AW)) u_prot (.addr_i(addr), .mode_i(bp_q), .locked_o(locked));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OP;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      addr_hi_q <= '0;
      addr_ph_q <= 1'b0;
      is_rd_q   <= 1'b0;
      wel_q     <= 1'b0;
      page_q    <= 1'b0;
      bp_q      <= PROT_NONE;
      tx_q      <= '0;
      tx_vld_q  <= 1'b0;
      we_q      <= 1'b0;
      adv_q     <= 1'b0;
      wdata_q   <= '0;
    end else begin
      we_q  <= 1'b0;
      adv_q <= 1'b0;
      if (!sel) begin
        state_q   <= ST_OP;
        bit_cnt_q <= '0;
        addr_ph_q <= 1'b0;
        tx_vld_q  <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt_q <= bit_cnt_q + BIT_W'(1);
          rx_sh_q   <= rx_byte[6:0];
        end
        if (byte_done) begin
          unique case (state_q)
            ST_OP: begin
              is_rd_q <= (rx_byte == OP_READ);
              case (rx_byte)
                OP_READ, OP_WRITE: state_q <= ST_ADDR;
                OP_RDSR:           state_q <= ST_RDSR;
                OP_WRSR:           state_q <= ST_WRSR;
                OP_WREN: begin wel_q <= 1'b1; state_q <= ST_IDLE; end
                OP_WRDI: begin wel_q <= 1'b0; state_q <= ST_IDLE; end
                default:           state_q <= ST_IDLE;
              endcase
            end
            ST_ADDR: begin
              addr_hi_q <= rx_byte;
              addr_ph_q <= 1'b1;
              if (addr_ph_q) state_q <= is_rd_q ? ST_READ : ST_WRITE;
            end
            ST_WRITE: begin
              we_q    <= wel_q && !locked;
              wdata_q <= rx_byte;
              adv_q   <= 1'b1;
            end
            ST_READ: adv_q <= 1'b1;
            ST_WRSR: begin
              if (wel_q) begin
                page_q <= rx_byte[5];
                bp_q   <= prot_e'(rx_byte[3:2]);
              end
              state_q <= ST_IDLE;
            end
            default: ;
          endcase
        end
        // a fall with bit_cnt 0 opens an output byte
        if (sck_fall) begin
          if (bit_cnt_q == '0 && state_q == ST_READ) begin
            tx_q     <= mem_rdata_i;
            tx_vld_q <= 1'b1;
          end else if (bit_cnt_q == '0 && state_q == ST_RDSR) begin
            tx_q     <= status;
            tx_vld_q <= 1'b1;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign so_o        = tx_q[7];
  assign so_oe_o     = sel && tx_vld_q;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = we_q;

  p_so_moves_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && (so_o != $past(so_o))) |-> $past(sck_fall))
    else $error("SO changed without a falling SCK edge");

  p_we_needs_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wel_q)
    else $error("write strobe while write latch clear");

  p_we_unlocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !locked)
    else $error("write strobe into protected region");

  p_we_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o)
    else $error("write strobe longer than one cycle");

  p_deselect_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel) |=> (bit_cnt_q == '0 && !so_oe_o && state_q == ST_OP))
    else $error("deselect did not abort command");
endmodule

// File: tb/sram_spi_slave_tb_top.sv
module sram_spi_slave_tb_top;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        so, so_oe, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 8'h00;

  always #5 clk = ~clk;

  sram_spi_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  // SRAM model and write strobe counter
  logic [7:0] sram [int];
  int we_cnt = 0;
  always @(posedge clk) begin
    if (mem_we) begin
      sram[int'(mem_addr)] = mem_wdata;
      we_cnt++;
    end
    mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
  end

  int total = 0, bad = 0;
  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] got_q[$];
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      exp_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      chk(g, e.v, e.tag);
    end
  end

  // reference model
  logic [7:0] ref_mem [int];
  logic       m_wel = 0, m_page = 0;
  logic [1:0] m_bp = 0;
  function automatic logic [7:0] m_status();
    return {2'b00, m_page, 1'b0, m_bp, m_wel, 1'b0};
  endfunction
  function automatic logic m_locked(input logic [12:0] a);
    case (m_bp)
      2'd0: return 1'b0;
      2'd1: return a >= 13'h1800;
      2'd2: return a >= 13'h1000;
      default: return 1'b1;
    endcase
  endfunction
  function automatic logic [12:0] m_next(input logic [12:0] a);
    if (m_page) return {a[12:5], a[4:0] + 5'd1};
    return a + 13'd1;
  endfunction
  function automatic logic [7:0] m_rd(input logic [12:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  // SPI driver
  logic cpol = 0;
  logic oe_seen = 0;
  int   unstable = 0;
  task automatic half();
    repeat (H) @(negedge clk);
  endtask
  task automatic cs_lo();
    sck = cpol;
    half();
    cs_n = 0;
    half();
  endtask
  task automatic cs_hi();
    if (!cpol) begin sck = 0; half(); end
    cs_n = 1;
    half(); half();
  endtask
  task automatic xbits(input logic [7:0] d, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < nb; i++) begin
      sck = 0;
      si  = d[7-i];
      half();
      r = {r[6:0], so};
      oe_seen |= so_oe;
      sck = 1;
      half();
      if (so_oe && so !== r[0]) unstable++;
    end
  endtask
  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    xbits(d, 8, r);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xbyte(op, r); cs_hi();
    if (op == 8'h06) m_wel = 1;
    if (op == 8'h04) m_wel = 0;
  endtask
  task automatic rdsr(input int n, input string tag);
    logic [7:0] r;
    cs_lo(); xbyte(8'h05, r);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{m_status(), tag});
      xbyte(8'h00, r);
      got_q.push_back(r);
    end
    cs_hi();
  endtask
  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    cs_lo(); xbyte(8'h01, r); xbyte(v, r); cs_hi();
    if (m_wel) begin m_page = v[5]; m_bp = v[3:2]; end
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d[$]);
    logic [7:0]  r;
    logic [12:0] ma = a[12:0];
    cs_lo(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    foreach (d[i]) begin
      xbyte(d[i], r);
      if (m_wel && !m_locked(ma)) ref_mem[int'(ma)] = d[i];
      ma = m_next(ma);
    end
    cs_hi();
  endtask
  task automatic rd(input logic [15:0] a, input int n, input string tag);
    logic [7:0]  r;
    logic [12:0] ma = a[12:0];
    cs_lo(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{m_rd(ma), tag});
      ma = m_next(ma);
      xbyte(8'h00, r);
      got_q.push_back(r);
    end
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 8'h01, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int snap;
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({7'd0, so_oe}, 8'h00, "R1 so_oe after reset");
    chk({7'd0, mem_we}, 8'h00, "R1 mem_we after reset");
    rdsr(3, "R1 R12 status repeat");

    // no latch: writes ignored
    snap = we_cnt;
    wr(16'h0010, '{8'hAA});
    chk(8'(we_cnt - snap), 8'h00, "R5 strobe without latch");
    rd(16'h0010, 1, "R5 data without latch");
    wrsr(8'h20);
    rdsr(1, "R5 R6 status write without latch");

    cmd(8'h06);
    rdsr(1, "R5 R6 latch bit");

    wr(16'hE100, '{8'h11, 8'h22, 8'h33, 8'h44});
    cpol = 1;
    rd(16'h0100, 4, "R2 R10 mode3 stream");
    rd(16'hE102, 2, "R10 upper field ignored");
    cpol = 0;

    wrsr(8'hFF);
    rdsr(1, "R6 writable bits");
    wrsr(8'h20);
    rdsr(1, "R6 page mode");
    wr(16'h003E, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
    rd(16'h0020, 2, "R9 write wrapped in page");
    rd(16'h003E, 2, "R9 page start");
    rd(16'h003F, 2, "R9 read wraps in page");
    rd(16'h0040, 1, "R9 next page untouched");

    wrsr(8'h00);
    wr(16'h1FFF, '{8'h5A, 8'h5B});
    rd(16'h1FFF, 2, "R8 array wrap");

    wrsr(8'h04);
    wr(16'h17FE, '{8'hC1, 8'hC2, 8'hC3});
    rd(16'h17FE, 3, "R7 quarter boundary");
    wrsr(8'h08);
    wr(16'h0FFF, '{8'hD1, 8'hD2});
    rd(16'h0FFF, 2, "R7 half boundary");
    wrsr(8'h0C);
    snap = we_cnt;
    wr(16'h0200, '{8'hE1});
    chk(8'(we_cnt - snap), 8'h00, "R7 all protected strobe");
    rd(16'h0200, 1, "R7 all protected data");
    wrsr(8'h00);

    cmd(8'h04);
    rdsr(1, "R5 latch cleared");
    wr(16'h0300, '{8'hF1});
    rd(16'h0300, 1, "R5 write after clear");

    // unknown op-code
    cs_lo(); oe_seen = 0;
    xbyte(8'h0B, r); xbyte(8'h00, r); xbyte(8'h00, r);
    chk({7'd0, oe_seen}, 8'h00, "R4 unknown op drives SO");
    cs_hi();

    // aborts
    cmd(8'h06);
    snap = we_cnt;
    cs_lo(); xbyte(8'h02, r); xbyte(8'h03, r); xbyte(8'h00, r); xbits(8'h77, 4, r); cs_hi();
    chk(8'(we_cnt - snap), 8'h00, "R11 partial data byte");
    chk({7'd0, so_oe}, 8'h00, "R11 SO released");
    rd(16'h0300, 1, "R11 data after abort");
    cs_lo(); xbyte(8'h03, r); xbyte(8'h01, r); xbyte(8'h00, r); xbits(8'h00, 3, r);
    sck = 0; half(); cs_n = 1; repeat (4) @(negedge clk);
    chk({7'd0, so_oe}, 8'h00, "R11 SO released mid-read");
    half();
    cs_lo(); xbits(8'h05, 3, r); cs_hi();
    rdsr(1, "R11 fresh op-code after partial");

    chk(8'(unstable), 8'h00, "R3 SO steady over high phase");

    repeat (20) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R10 scoreboard drained");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule